// File: doc/BRIEF.md
# Time-Shared Pipelined Add-Compare-Select Engine

This block is one add-compare-select engine for a trellis decoder in which several engines share the trellis states. Each engine owns a fixed group of states and works through them one per clock, in a fixed order. Every clock it can accept one state's old path metrics together with the matching branch metrics, one pair for each incoming branch. It adds each pair, choosing the best sum, and returns the new path metric and the index of the branch that won.

The add and compare logic is cut into a configurable number of register stages. This lets the metrics of different states be in flight at the same time, which is possible because the states handled in one pass do not depend on each other. A valid bit and a state tag enter with each set of operands and leave with its result, so the path metric store around the engine knows where to write.

A parameter picks the selection sense. Distance mode keeps the smallest sum and likelihood mode keeps the largest. Metrics are unsigned and sums clamp at the top code. Branch metric generation, traceback and metric storage sit outside the block.

Top module: `shared_acs_top`

## Requirements
- R1: In distance mode (SELECT_MAX = 0), `outMetric` equals the smallest of the DEGREE candidate sums, where candidate k is old metric k (bits k*METRIC_W upward of `oldMetrics`) plus branch metric k (same field of `branchMetrics`).
- R2: A candidate sum that exceeds 2^METRIC_W - 1 is replaced by 2^METRIC_W - 1 and never wraps.
- R3: `outDecision` is the index k of the winning candidate. When several candidates share the best value, the lowest index wins.
- R4: A result leaves exactly PIPE_STAGES clock edges after its operands were sampled with `inValid` high.
- R5: The engine accepts a new state on every clock edge. Results of back-to-back states do not disturb each other and all come out in issue order.
- R6: `outValid` and `outTag` come out in the same cycle as the result they belong to. `outTag` repeats the `inTag` given with the operands, and no result appears that was never issued.
- R7: In likelihood mode (SELECT_MAX = 1), `outMetric` is the largest candidate sum, with the same saturation and lowest-index tie rule.
- R8: Cycles with `inValid` low produce no result. `outValid` stays low for them, and `outMetric` and `outDecision` keep the last result.
- R9: While `rst_n` is low, and on the first cycle after it is released, `outValid` is low. Under reset `outMetric`, `outDecision` and `outTag` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operands on the inputs belong to a state to process |
| inTag | input | TAG_W | Number of the state being processed |
| oldMetrics | input | DEGREE*METRIC_W | Old path metrics of the source states, branch k in field k |
| branchMetrics | input | DEGREE*METRIC_W | Branch metrics of the incoming transitions, branch k in field k |
| outValid | output | 1 | A new path metric is present |
| outTag | output | TAG_W | State number of the present result |
| outMetric | output | METRIC_W | New path metric |
| outDecision | output | IDX_W | Index of the winning incoming branch |

## Verification
The bench builds two copies of the block. The first uses DEGREE = 4, PIPE_STAGES = 3 in distance mode. This gives one register after the adders and one after each compare level, so three states are in flight during a back-to-back stream, and four candidates allow ties at separated indices. The second uses DEGREE = 2, PIPE_STAGES = 1 in likelihood mode. It covers the case where the adders and the compare stage are merged into one cycle with a single register, where the first and last stage load strobes coincide, and the largest-sum rule. Sums near the top code exercise saturation in both copies.

// File: rtl/acs_pkg.sv
package acs_pkg;

  // Strobes from the sequencing logic to the arithmetic pipeline.
  // firstLoad gates the entry register (operands are only captured for
  // real states); lastLoad gates the result register so the outputs hold
  // across bubbles. Registers in between advance every cycle.
  typedef struct packed {
    logic firstLoad;
    logic lastLoad;
  } acs_strobe_t;

  // Number of compare levels needed to reduce a power-of-two candidate set.
  function automatic int unsigned treeLevels(input int unsigned degree);
    int unsigned lv;
    lv = 0;
    while ((1 << lv) < degree) lv++;
    return lv;
  endfunction

endpackage

// File: rtl/acs_select.sv
module acs_select #(
  parameter int unsigned METRIC_W   = 8,
  parameter int unsigned IDX_W      = 2,
  parameter bit          SELECT_MAX = 1'b0
) (
  input  logic [METRIC_W-1:0] aVal,
  input  logic [IDX_W-1:0]    aIdx,
  input  logic [METRIC_W-1:0] bVal,
  input  logic [IDX_W-1:0]    bIdx,
  output logic [METRIC_W-1:0] wVal,
  output logic [IDX_W-1:0]    wIdx
);

  logic takeB;

  // The a side always carries the lower branch indices, so only a strict
  // improvement lets b win: equal values stay with the lower index.
  generate
    if (SELECT_MAX) begin : likelihoodCmp
      assign takeB = (bVal > aVal);
    end else begin : distanceCmp
      assign takeB = (bVal < aVal);
    end
  endgenerate

  assign wVal = takeB ? bVal : aVal;
  assign wIdx = takeB ? bIdx : aIdx;

endmodule

// File: rtl/acs_datapath.sv
module acs_datapath
  import acs_pkg::*;
#(
  parameter int unsigned DEGREE      = 4,
  parameter int unsigned METRIC_W    = 8,
  parameter int unsigned PIPE_STAGES = 3,
  parameter bit          SELECT_MAX  = 1'b0,
  localparam int unsigned IDX_W      = (DEGREE > 1) ? $clog2(DEGREE) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  acs_strobe_t                  strobe,
  input  logic [DEGREE*METRIC_W-1:0]   oldMetrics,
  input  logic [DEGREE*METRIC_W-1:0]   branchMetrics,
  output logic [METRIC_W-1:0]          bestMetric,
  output logic [IDX_W-1:0]             bestIdx
);

  // Level 0 is the adder row, levels 1..TREE_LV halve the candidate set.
  localparam int unsigned TREE_LV = treeLevels(DEGREE);
  localparam int unsigned NLEV    = TREE_LV + 1;

  generate
    for (genvar l = 0; l < NLEV; l++) begin : lv
      localparam int unsigned NOUT = DEGREE >> l;
      // Registers placed before and after this level; a register sits
      // behind the level when the count steps up. PIPE_STAGES registers
      // are spread evenly over NLEV levels, the last level always ends
      // with one.
      localparam int unsigned S0 = (l * PIPE_STAGES) / NLEV;
      localparam int unsigned S1 = ((l + 1) * PIPE_STAGES) / NLEV;

      logic [NOUT*METRIC_W-1:0] cVal;
      logic [NOUT*IDX_W-1:0]    cIdx;
      logic [NOUT*METRIC_W-1:0] qVal;
      logic [NOUT*IDX_W-1:0]    qIdx;

      if (l == 0) begin : addRow
        for (genvar k = 0; k < DEGREE; k++) begin : addr
          logic [METRIC_W:0] wide;
          assign wide = {1'b0, oldMetrics[k*METRIC_W +: METRIC_W]}
                      + {1'b0, branchMetrics[k*METRIC_W +: METRIC_W]};
          // Clamp at the top code instead of wrapping.
          assign cVal[k*METRIC_W +: METRIC_W] =
            wide[METRIC_W] ? {METRIC_W{1'b1}} : wide[METRIC_W-1:0];
          assign cIdx[k*IDX_W +: IDX_W] = IDX_W'(k);
        end
      end else begin : cmpRow
        for (genvar k = 0; k < NOUT; k++) begin : cs
          acs_select #(
            .METRIC_W  (METRIC_W),
            .IDX_W     (IDX_W),
            .SELECT_MAX(SELECT_MAX)
          ) sel_i (
            .aVal(lv[l-1].qVal[(2*k)*METRIC_W +: METRIC_W]),
            .aIdx(lv[l-1].qIdx[(2*k)*IDX_W +: IDX_W]),
            .bVal(lv[l-1].qVal[(2*k+1)*METRIC_W +: METRIC_W]),
            .bIdx(lv[l-1].qIdx[(2*k+1)*IDX_W +: IDX_W]),
            .wVal(cVal[k*METRIC_W +: METRIC_W]),
            .wIdx(cIdx[k*IDX_W +: IDX_W])
          );
        end
      end

      if (S1 > S0) begin : pipeReg
        logic ld;
        assign ld = ((S0 == 0) ? strobe.firstLoad : 1'b1)
                  & ((S0 == PIPE_STAGES - 1) ? strobe.lastLoad : 1'b1);
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            qVal <= '0;
            qIdx <= '0;
          end else if (ld) begin
            qVal <= cVal;
            qIdx <= cIdx;
          end
        end
      end else begin : passThru
        assign qVal = cVal;
        assign qIdx = cIdx;
      end
    end
  endgenerate

  assign bestMetric = lv[NLEV-1].qVal;
  assign bestIdx    = lv[NLEV-1].qIdx;

endmodule

// File: rtl/acs_ctrl.sv
module acs_ctrl
  import acs_pkg::*;
#(
  parameter int unsigned PIPE_STAGES = 3,
  parameter int unsigned TAG_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inValid,
  input  logic [TAG_W-1:0] inTag,
  output acs_strobe_t      strobe,
  output logic             outValid,
  output logic [TAG_W-1:0] outTag
);

  logic [PIPE_STAGES-1:0] vPipe;
  logic [TAG_W-1:0]       tagPipe [PIPE_STAGES];

  // Valid bits advance every cycle; a tag moves only with a live state so
  // the tag at the output stays with the last result during bubbles.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vPipe <= '0;
      for (int s = 0; s < PIPE_STAGES; s++) tagPipe[s] <= '0;
    end else begin
      vPipe[0] <= inValid;
      if (inValid) tagPipe[0] <= inTag;
      for (int s = 1; s < PIPE_STAGES; s++) begin
        vPipe[s] <= vPipe[s-1];
        if (vPipe[s-1]) tagPipe[s] <= tagPipe[s-1];
      end
    end
  end

  assign strobe.firstLoad = inValid;

  generate
    if (PIPE_STAGES == 1) begin : singleStage
      assign strobe.lastLoad = inValid;
    end else begin : multiStage
      assign strobe.lastLoad = vPipe[PIPE_STAGES-2];
    end
  endgenerate

  assign outValid = vPipe[PIPE_STAGES-1];
  assign outTag   = tagPipe[PIPE_STAGES-1];

endmodule

// File: rtl/shared_acs_top.sv
module shared_acs_top
  import acs_pkg::*;
#(
  parameter int unsigned DEGREE      = 4,
  parameter int unsigned METRIC_W    = 8,
  parameter int unsigned TAG_W       = 4,
  parameter int unsigned PIPE_STAGES = 3,
  parameter bit          SELECT_MAX  = 1'b0,
  localparam int unsigned IDX_W      = (DEGREE > 1) ? $clog2(DEGREE) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       inValid,
  input  logic [TAG_W-1:0]           inTag,
  input  logic [DEGREE*METRIC_W-1:0] oldMetrics,
  input  logic [DEGREE*METRIC_W-1:0] branchMetrics,
  output logic                       outValid,
  output logic [TAG_W-1:0]           outTag,
  output logic [METRIC_W-1:0]        outMetric,
  output logic [IDX_W-1:0]           outDecision
);

  acs_strobe_t strobe;

  acs_ctrl #(
    .PIPE_STAGES(PIPE_STAGES),
    .TAG_W      (TAG_W)
  ) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .inValid (inValid),
    .inTag   (inTag),
    .strobe  (strobe),
    .outValid(outValid),
    .outTag  (outTag)
  );

  acs_datapath #(
    .DEGREE     (DEGREE),
    .METRIC_W   (METRIC_W),
    .PIPE_STAGES(PIPE_STAGES),
    .SELECT_MAX (SELECT_MAX)
  ) dp_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe       (strobe),
    .oldMetrics   (oldMetrics),
    .branchMetrics(branchMetrics),
    .bestMetric   (outMetric),
    .bestIdx      (outDecision)
  );

endmodule

// File: rtl/shared_acs_chk.sv
module shared_acs_chk #(
  parameter int unsigned METRIC_W    = 8,
  parameter int unsigned IDX_W       = 2,
  parameter int unsigned PIPE_STAGES = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                inValid,
  input logic                outValid,
  input logic [METRIC_W-1:0] outMetric,
  input logic [IDX_W-1:0]    outDecision
);

  logic [7:0] inFlight;
  logic [7:0] idleCnt;
  logic       freshOut;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inFlight <= '0;
      idleCnt  <= 8'(PIPE_STAGES);
      freshOut <= 1'b1;
    end else begin
      freshOut <= 1'b0;
      inFlight <= inFlight + 8'(inValid) - 8'(outValid);
      if (inValid) idleCnt <= '0;
      else if (idleCnt < 8'(PIPE_STAGES)) idleCnt <= idleCnt + 8'd1;
    end
  end

  // R9
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freshOut |-> !outValid);

  // R8
  hold_on_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !outValid |-> ($stable(outMetric) && $stable(outDecision)));

  // R8
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idleCnt >= 8'(PIPE_STAGES)) |-> !outValid);

  // R4
  in_flight_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inFlight <= 8'(PIPE_STAGES));

  // R6
  no_phantom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> (inFlight != 8'd0));

endmodule

bind shared_acs_top shared_acs_chk #(
  .METRIC_W   (METRIC_W),
  .IDX_W      (IDX_W),
  .PIPE_STAGES(PIPE_STAGES)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .inValid    (inValid),
  .outValid   (outValid),
  .outMetric  (outMetric),
  .outDecision(outDecision)
);

// File: tb/shared_acs_top_tb.sv
module shared_acs_top_tb_top;

  localparam int D  = 4;
  localparam int W  = 8;
  localparam int TW = 4;
  localparam int PS = 3;
  localparam int D2 = 2;
  localparam int PS2 = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  // distance-mode copy
  logic            inValid = 1'b0;
  logic [TW-1:0]   inTag = '0;
  logic [D*W-1:0]  oldM = '0;
  logic [D*W-1:0]  brM = '0;
  logic            outValid;
  logic [TW-1:0]   outTag;
  logic [W-1:0]    outMetric;
  logic [1:0]      outDecision;

  // likelihood-mode copy
  logic            mInValid = 1'b0;
  logic [TW-1:0]   mInTag = '0;
  logic [D2*W-1:0] mOld = '0;
  logic [D2*W-1:0] mBr = '0;
  logic            mOutValid;
  logic [TW-1:0]   mOutTag;
  logic [W-1:0]    mOutMetric;
  logic            mOutDecision;

  shared_acs_top #(.DEGREE(D), .METRIC_W(W), .TAG_W(TW), .PIPE_STAGES(PS),
                   .SELECT_MAX(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inTag(inTag),
    .oldMetrics(oldM), .branchMetrics(brM), .outValid(outValid),
    .outTag(outTag), .outMetric(outMetric), .outDecision(outDecision));

  shared_acs_top #(.DEGREE(D2), .METRIC_W(W), .TAG_W(TW), .PIPE_STAGES(PS2),
                   .SELECT_MAX(1'b1)) dutMax_i (
    .clk(clk), .rst_n(rst_n), .inValid(mInValid), .inTag(mInTag),
    .oldMetrics(mOld), .branchMetrics(mBr), .outValid(mOutValid),
    .outTag(mOutTag), .outMetric(mOutMetric), .outDecision(mOutDecision));

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 1'b0;

  bit pending  [16];
  int expMet   [16];
  int expIdx   [16];
  int issueCyc [16];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Reference: saturated sums, best by mode, lowest index on ties.
  task automatic refBest(input logic [31:0] o, input logic [31:0] b,
                         input int degree, input bit maxMode,
                         output int met, output int idx);
    met = -1;
    idx = 0;
    for (int k = 0; k < degree; k++) begin
      int s;
      s = int'(o[k*8 +: 8]) + int'(b[k*8 +: 8]);
      if (s > 255) s = 255;
      if (met < 0 || (maxMode ? (s > met) : (s < met))) begin
        met = s;
        idx = k;
      end
    end
  endtask

  function automatic logic [31:0] pack4(input int a, input int b, input int c, input int d);
    return {d[7:0], c[7:0], b[7:0], a[7:0]};
  endfunction

  // Scoreboard for the distance-mode copy.
  always @(negedge clk) begin
    if (rst_n && outValid) begin
      int t;
      t = int'(outTag);
      check(pending[t], "R6", "result carries an issued tag", t, t);
      if (pending[t]) begin
        check(int'(outMetric) == expMet[t], "R1", "new path metric", outMetric, expMet[t]);
        check(int'(outDecision) == expIdx[t], "R3", "winning branch index", outDecision, expIdx[t]);
        check(cyc - issueCyc[t] == PS, "R4", "latency in cycles", cyc - issueCyc[t], PS);
        pending[t] = 1'b0;
      end
    end
  end

  // Called at a falling edge; returns one falling edge later.
  task automatic issue(input int tag, input logic [31:0] o, input logic [31:0] b);
    int m;
    int i;
    refBest(o, b, D, 1'b0, m, i);
    expMet[tag] = m;
    expIdx[tag] = i;
    issueCyc[tag] = cyc;
    pending[tag] = 1'b1;
    inValid = 1'b1;
    inTag = TW'(tag);
    oldM = o;
    brM = b;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic drain(input string req);
    int left;
    repeat (PS + 2) @(negedge clk);
    left = 0;
    for (int t = 0; t < 16; t++) if (pending[t]) left++;
    check(left == 0, req, "results still outstanding", left, 0);
  endtask

  task automatic t_reset();
    check(outValid == 1'b0, "R9", "valid under reset", outValid, 0);
    check(outMetric == '0, "R9", "metric under reset", outMetric, 0);
    check(outDecision == '0, "R9", "decision under reset", outDecision, 0);
    check(outTag == '0, "R9", "tag under reset", outTag, 0);
    check(mOutValid == 1'b0, "R9", "likelihood copy valid under reset", mOutValid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, "R9", "valid first cycle after reset", outValid, 0);
  endtask

  task automatic t_basic();
    // R1 R3: distinct patterns, one at a time
    issue(1, pack4(10, 20, 30, 40), pack4(5, 1, 1, 1));   // 15,21,31,41 -> 15 @0
    drain("R1");
    issue(2, pack4(90, 80, 70, 5), pack4(9, 9, 9, 9));     // min at 3
    drain("R1");
    issue(3, pack4(100, 20, 60, 60), pack4(0, 50, 1, 2));  // 100,70,61,62 -> 61 @2
    drain("R1");
  endtask

  task automatic t_ties();
    // R3: all equal -> index 0; equal pair at 1 and 3 -> index 1
    issue(4, pack4(10, 20, 30, 40), pack4(30, 20, 10, 0));
    drain("R3");
    issue(5, pack4(40, 20, 50, 10), pack4(10, 10, 10, 20));
    drain("R3");
    issue(6, pack4(0, 0, 0, 0), pack4(0, 0, 0, 0));
    drain("R3");
  endtask

  task automatic t_saturate();
    // R2: clamped sums, wrapping would pick index 2 with value 0
    issue(7, pack4(200, 240, 255, 250), pack4(60, 30, 1, 4));  // 255,255,255,254
    drain("R2");
    issue(8, pack4(250, 250, 250, 250), pack4(10, 20, 6, 5));  // all 255 -> @0
    drain("R2");
  endtask

  task automatic t_stream();
    // R5: sixteen states back to back, values vary with the tag
    for (int t = 0; t < 16; t++) begin
      int m;
      int i;
      logic [31:0] o;
      logic [31:0] b;
      for (int k = 0; k < 4; k++) begin
        o[k*8 +: 8] = 8'((t * 37 + k * 53) & 255);
        b[k*8 +: 8] = 8'((t * 11 + k * 29 + 7) & 255);
      end
      refBest(o, b, D, 1'b0, m, i);
      expMet[t] = m;
      expIdx[t] = i;
      issueCyc[t] = cyc;
      pending[t] = 1'b1;
      inValid = 1'b1;
      inTag = TW'(t);
      oldM = o;
      brM = b;
      @(negedge clk);
    end
    inValid = 1'b0;
    drain("R5");
  endtask

  task automatic t_bubble();
    // R8: alternating live and idle slots, then idle outputs must hold
    issue(9, pack4(33, 44, 55, 66), pack4(1, 2, 3, 4));
    issue(10, pack4(70, 12, 80, 90), pack4(0, 0, 0, 0));
    @(negedge clk);
    issue(11, pack4(5, 6, 7, 3), pack4(9, 9, 9, 9));    // 12 @3
    drain("R8");
    for (int n = 0; n < 4; n++) begin
      check(outValid == 1'b0, "R8", "valid during idle", outValid, 0);
      check(int'(outMetric) == 12, "R8", "metric held during idle", outMetric, 12);
      check(int'(outDecision) == 3, "R8", "decision held during idle", outDecision, 3);
      check(int'(outTag) == 11, "R6", "tag held during idle", outTag, 11);
      // R8: operands on the bus with valid low are ignored
      oldM = pack4(0, 0, 0, 0);
      brM = pack4(0, 0, 0, 0);
      @(negedge clk);
    end
  endtask

  task automatic maxCase(input int tag, input int o0, input int o1,
                         input int b0, input int b1, input string req);
    int m;
    int i;
    refBest({16'd0, o1[7:0], o0[7:0]}, {16'd0, b1[7:0], b0[7:0]}, D2, 1'b1, m, i);
    mInValid = 1'b1;
    mInTag = TW'(tag);
    mOld = {o1[7:0], o0[7:0]};
    mBr = {b1[7:0], b0[7:0]};
    @(negedge clk);
    mInValid = 1'b0;
    check(mOutValid == 1'b1, "R4", "likelihood copy valid after one stage", mOutValid, 1);
    check(int'(mOutMetric) == m, req, "likelihood metric", mOutMetric, m);
    check(int'(mOutDecision) == i, req, "likelihood decision", mOutDecision, i);
    check(int'(mOutTag) == tag, "R6", "likelihood tag", mOutTag, tag);
    @(negedge clk);
    check(mOutValid == 1'b0, "R8", "likelihood valid after idle", mOutValid, 0);
  endtask

  task automatic t_max();
    maxCase(1, 10, 200, 5, 3, "R7");      // 15 vs 203 -> 203 @1
    maxCase(2, 100, 90, 0, 10, "R7");     // tie 100 -> @0
    maxCase(3, 250, 250, 10, 20, "R2");   // both clamp 255 -> @0
    maxCase(4, 200, 40, 20, 40, "R7");    // 220 vs 80 -> @0
  endtask

  initial begin
    for (int t = 0; t < 16; t++) pending[t] = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_ties();
    t_saturate();
    t_stream();
    t_bubble();
    t_max();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R5 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule